// File: doc/BRIEF.md
# Event-Steered Up/Down Timer Counter

This block is a timer counter whose value moves between zero and a programmable TOP limit. The value changes in single steps on a prescaler enable, or on event edges. Two asynchronous event inputs steer it. Each input is synchronized and can be inverted, then gated by its own enable. A per-input action code then maps it onto one counter operation. Input 0 can retrigger, count on its edges, start a one-shot run, increment, or gate counting by its level. Input 1 can retrigger, set the direction, stop the counter, or decrement.

The counter drives single-cycle output event pulses. There is one for overflow/underflow, one for retrigger, one for every counter step, and one for each compare channel whose value the counter lands on. Every pulse has its own enable. All pulses are registered and line up with the count value they describe. A system integrator wires the pulses into an event routing fabric and sets the action codes so that external happenings drive the timer.

Top module: `evt_timer_ctrl`

## Requirements
- R1: After reset the count is 0, the direction is up (`dir_o`=0), the counter is stopped (`run_o`=0) and every output pulse is low.
- R2: Each raw event passes two synchronizer flops. It is then XORed with its invert bit, and a registered previous value of that level finds the rising edges. A raw change before clock edge k takes effect on edge k+2. An input whose enable bit is 0 causes no action, and inverting a low input produces a rising edge.
- R3: Retrigger (input 0 code 1, or input 1 code 1) loads 0 when the direction is up or TOP when it is down, sets the counter running, and produces one retrigger pulse.
- R4: When input 0 is not enabled in code 2 or 5, a running counter takes one step in the current direction on each cycle with `presc_tick_i` high.
- R5: Input 0 code 2 makes each rising edge one step in the current direction, and the prescaler enable then causes no steps.
- R6: Input 0 code 3 starts a stopped counter on a rising edge, and edges while it runs change nothing. In this mode a prescaled step that lands on TOP (up) or on 0 (down) stops the counter.
- R7: Input 0 code 4 adds one on each rising edge, and input 1 code 4 subtracts one on each rising edge, whatever the direction.
- R8: Input 0 code 5 makes the counter step on every prescaler enable while that input's level is high, whether or not it is running.
- R9: Input 1 code 2 sets the direction to the input's level (high = down). Input 1 code 3 stops the counter on a rising edge, and the count then stays frozen under prescaler enables.
- R10: An up step from a value at or above TOP gives 0, and a down step from 0 gives TOP. Each such wrap produces an overflow pulse.
- R11: Compare pulse n goes high for one cycle, together with the new count, whenever a step or load leaves the count equal to compare value n.
- R12: Each output pulse (overflow, retrigger, step, compare n) is one cycle long and appears only when its enable bit is 1. A step pulse accompanies every step.
- R13: In one cycle, retrigger overrides every other action, stop overrides start, and only one step is taken. Step sources rank count-on-edge first, then increment, then decrement, then the prescaled step. Codes not listed act as no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| presc_tick_i | input | 1 | Prescaled count enable |
| evt_i | input | 2 | Raw asynchronous event inputs |
| evt_inv_i | input | 2 | Per-input polarity invert |
| evt_en_i | input | 2 | Per-input action enable |
| ev0_act_i | input | 3 | Action code of input 0 |
| ev1_act_i | input | 3 | Action code of input 1 |
| top_i | input | CNT_W | TOP limit |
| cmp_i | input | NUM_CC*CNT_W | Compare values, channel n at bits n*CNT_W |
| ovf_oe_i | input | 1 | Overflow pulse enable |
| trg_oe_i | input | 1 | Retrigger pulse enable |
| cnt_oe_i | input | 1 | Step pulse enable |
| mc_oe_i | input | NUM_CC | Compare pulse enables |
| count_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Direction, 1 = down |
| run_o | output | 1 | Counter running |
| ovf_evt_o | output | 1 | Overflow/underflow pulse |
| trg_evt_o | output | 1 | Retrigger pulse |
| cnt_evt_o | output | 1 | Step pulse |
| mc_evt_o | output | NUM_CC | Compare match pulses |

## Verification
A wrong run flag or direction is easy to miss directly. It shows at the ports on the next prescaler enable, as a step that should not happen or that goes the wrong way. A bad synchronizer or edge register shifts every event action by a whole cycle, or doubles it, and this shows at once in `count_o`. A wrong wrap or compare decision shows in the same cycle as the count it concerns, because the pulses are registered alongside the count. The bench therefore compares every output on every cycle against its own cycle-level model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [2:0] {
      EV0_OFF    = 3'd0,
      EV0_RETRIG = 3'd1,
      EV0_COUNT  = 3'd2,
      EV0_START  = 3'd3,
      EV0_INC    = 3'd4,
      EV0_GATED  = 3'd5
   } ev0_act_e;

   typedef enum logic [2:0] {
      EV1_OFF    = 3'd0,
      EV1_RETRIG = 3'd1,
      EV1_DIR    = 3'd2,
      EV1_STOP   = 3'd3,
      EV1_DEC    = 3'd4
   } ev1_act_e;

   // Decoded per-cycle request to the counter core
   typedef struct packed {
      logic retrig;
      logic start;
      logic stop;
      logic cnt_edge;
      logic inc;
      logic dec;
      logic gated_mode;
      logic gate_lvl;
      logic free_mode;
      logic start_mode;
      logic dir_valid;
      logic dir_val;
   } evt_cmd_t;

endpackage

// File: rtl/evt_in_cond.sv
module evt_in_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   input  logic inv_i,
   output logic lvl_o,
   output logic rise_o
);

   logic synced;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = raw_i;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= 1'b0;
            else         s_q <= raw_i;
         end
         assign synced = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
         end
         assign synced = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign lvl_o = synced ^ inv_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/evt_act_decode.sv
module evt_act_decode
   import evt_timer_pkg::*;
(
   input  logic [1:0] lvl_i,
   input  logic [1:0] rise_i,
   input  logic [1:0] en_i,
   input  logic [2:0] ev0_act_i,
   input  logic [2:0] ev1_act_i,
   output evt_cmd_t   cmd_o
);

   ev0_act_e a0;
   ev1_act_e a1;
   logic     e0_edge;
   logic     e1_edge;

   assign a0      = ev0_act_e'(ev0_act_i);
   assign a1      = ev1_act_e'(ev1_act_i);
   assign e0_edge = en_i[0] & rise_i[0];
   assign e1_edge = en_i[1] & rise_i[1];

   always_comb begin
      cmd_o = '0;
      cmd_o.free_mode = 1'b1;
      case (a0)
         EV0_RETRIG: cmd_o.retrig   = e0_edge;
         EV0_COUNT: begin
            cmd_o.cnt_edge  = e0_edge;
            cmd_o.free_mode = ~en_i[0];
         end
         EV0_START: begin
            cmd_o.start      = e0_edge;
            cmd_o.start_mode = en_i[0];
         end
         EV0_INC:   cmd_o.inc      = e0_edge;
         EV0_GATED: begin
            cmd_o.gated_mode = en_i[0];
            cmd_o.gate_lvl   = en_i[0] & lvl_i[0];
            cmd_o.free_mode  = ~en_i[0];
         end
         default: ;
      endcase
      case (a1)
         EV1_RETRIG: cmd_o.retrig = cmd_o.retrig | e1_edge;
         EV1_DIR: begin
            cmd_o.dir_valid = en_i[1];
            cmd_o.dir_val   = lvl_i[1];
         end
         EV1_STOP:   cmd_o.stop = e1_edge;
         EV1_DEC:    cmd_o.dec  = e1_edge;
         default: ;
      endcase
   end

endmodule

// File: rtl/evt_cnt_core.sv
module evt_cnt_core
   import evt_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  evt_cmd_t         cmd_i,
   input  logic [CNT_W-1:0] top_i,
   output logic [CNT_W-1:0] count_o,
   output logic             dir_o,
   output logic             run_o,
   output logic [CNT_W-1:0] nxt_cnt_o,
   output logic             step_o,
   output logic             wrap_o,
   output logic             load_o
);

   logic [CNT_W-1:0] count_q, cnt_d;
   logic             dir_q, dir_d;
   logic             run_q, run_d;
   logic             evt_step, tick_step, step_dn;

   always_comb begin
      cnt_d     = count_q;
      run_d     = run_q;
      dir_d     = cmd_i.dir_valid ? cmd_i.dir_val : dir_q;
      load_o    = 1'b0;
      wrap_o    = 1'b0;
      evt_step  = 1'b0;
      tick_step = 1'b0;
      step_dn   = dir_q;
      if (cmd_i.retrig) begin
         load_o = 1'b1;
         run_d  = 1'b1;
         cnt_d  = dir_q ? top_i : '0;
      end else begin
         if (cmd_i.start && !run_q) run_d = 1'b1;
         if (cmd_i.stop)            run_d = 1'b0;
         tick_step = tick_i &&
                     ((cmd_i.gated_mode && cmd_i.gate_lvl) ||
                      (cmd_i.free_mode && run_q && !cmd_i.stop));
         if (cmd_i.cnt_edge) begin
            evt_step = 1'b1;
            step_dn  = dir_q;
         end else if (cmd_i.inc) begin
            evt_step = 1'b1;
            step_dn  = 1'b0;
         end else if (cmd_i.dec) begin
            evt_step = 1'b1;
            step_dn  = 1'b1;
         end
         if (evt_step || tick_step) begin
            if (step_dn) begin
               if (count_q == '0) begin
                  cnt_d  = top_i;
                  wrap_o = 1'b1;
               end else begin
                  cnt_d = count_q - 1'b1;
               end
            end else begin
               if (count_q >= top_i) begin
                  cnt_d  = '0;
                  wrap_o = 1'b1;
               end else begin
                  cnt_d = count_q + 1'b1;
               end
            end
            if (!evt_step && cmd_i.start_mode &&
                ((step_dn && cnt_d == '0) || (!step_dn && cnt_d == top_i)))
               run_d = 1'b0;
         end
      end
   end

   assign step_o    = evt_step | tick_step;
   assign nxt_cnt_o = cnt_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
         dir_q   <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         count_q <= cnt_d;
         dir_q   <= dir_d;
         run_q   <= run_d;
      end
   end

   assign count_o = count_q;
   assign dir_o   = dir_q;
   assign run_o   = run_q;

endmodule

// File: rtl/evt_out_gen.sv
module evt_out_gen #(
   parameter int CNT_W  = 16,
   parameter int NUM_CC = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [CNT_W-1:0]        nxt_cnt_i,
   input  logic                    step_i,
   input  logic                    wrap_i,
   input  logic                    load_i,
   input  logic [NUM_CC*CNT_W-1:0] cmp_i,
   input  logic                    ovf_oe_i,
   input  logic                    trg_oe_i,
   input  logic                    cnt_oe_i,
   input  logic [NUM_CC-1:0]       mc_oe_i,
   output logic                    ovf_evt_o,
   output logic                    trg_evt_o,
   output logic                    cnt_evt_o,
   output logic [NUM_CC-1:0]       mc_evt_o
);

   logic upd;
   assign upd = step_i | load_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_evt_o <= 1'b0;
         trg_evt_o <= 1'b0;
         cnt_evt_o <= 1'b0;
      end else begin
         ovf_evt_o <= wrap_i & ovf_oe_i;
         trg_evt_o <= load_i & trg_oe_i;
         cnt_evt_o <= step_i & cnt_oe_i;
      end
   end

   generate
      for (genvar n = 0; n < NUM_CC; n++) begin : g_cc
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) mc_evt_o[n] <= 1'b0;
            else         mc_evt_o[n] <= upd & mc_oe_i[n] &
                                        (nxt_cnt_i == cmp_i[n*CNT_W +: CNT_W]);
         end
      end
   endgenerate

endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
   import evt_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_CC      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    presc_tick_i,
   input  logic [1:0]              evt_i,
   input  logic [1:0]              evt_inv_i,
   input  logic [1:0]              evt_en_i,
   input  logic [2:0]              ev0_act_i,
   input  logic [2:0]              ev1_act_i,
   input  logic [CNT_W-1:0]        top_i,
   input  logic [NUM_CC*CNT_W-1:0] cmp_i,
   input  logic                    ovf_oe_i,
   input  logic                    trg_oe_i,
   input  logic                    cnt_oe_i,
   input  logic [NUM_CC-1:0]       mc_oe_i,
   output logic [CNT_W-1:0]        count_o,
   output logic                    dir_o,
   output logic                    run_o,
   output logic                    ovf_evt_o,
   output logic                    trg_evt_o,
   output logic                    cnt_evt_o,
   output logic [NUM_CC-1:0]       mc_evt_o
);

   localparam int NUM_EV = 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("evt_timer_ctrl: CNT_W must lie in 2..32");
      end
      if (NUM_CC < 1 || NUM_CC > 8) begin : g_bad_cc
         $error("evt_timer_ctrl: NUM_CC must lie in 1..8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("evt_timer_ctrl: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [NUM_EV-1:0] lvl, rise;
   evt_cmd_t          cmd;
   logic [CNT_W-1:0]  nxt_cnt;
   logic              step, wrap, load;

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_in
         evt_in_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (evt_i[i]),
            .inv_i  (evt_inv_i[i]),
            .lvl_o  (lvl[i]),
            .rise_o (rise[i])
         );
      end
   endgenerate

   evt_act_decode dec_i (
      .lvl_i     (lvl),
      .rise_i    (rise),
      .en_i      (evt_en_i),
      .ev0_act_i (ev0_act_i),
      .ev1_act_i (ev1_act_i),
      .cmd_o     (cmd)
   );

   evt_cnt_core #(.CNT_W(CNT_W)) core_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (presc_tick_i),
      .cmd_i     (cmd),
      .top_i     (top_i),
      .count_o   (count_o),
      .dir_o     (dir_o),
      .run_o     (run_o),
      .nxt_cnt_o (nxt_cnt),
      .step_o    (step),
      .wrap_o    (wrap),
      .load_o    (load)
   );

   evt_out_gen #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) out_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nxt_cnt_i (nxt_cnt),
      .step_i    (step),
      .wrap_i    (wrap),
      .load_i    (load),
      .cmp_i     (cmp_i),
      .ovf_oe_i  (ovf_oe_i),
      .trg_oe_i  (trg_oe_i),
      .cnt_oe_i  (cnt_oe_i),
      .mc_oe_i   (mc_oe_i),
      .ovf_evt_o (ovf_evt_o),
      .trg_evt_o (trg_evt_o),
      .cnt_evt_o (cnt_evt_o),
      .mc_evt_o  (mc_evt_o)
   );

endmodule

// File: rtl/evt_timer_ctrl_chk.sv
module evt_timer_ctrl_chk #(
   parameter int CNT_W  = 16,
   parameter int NUM_CC = 2
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic [CNT_W-1:0]        top_i,
   input logic [NUM_CC*CNT_W-1:0] cmp_i,
   input logic                    ovf_oe_i,
   input logic                    trg_oe_i,
   input logic                    cnt_oe_i,
   input logic [NUM_CC-1:0]       mc_oe_i,
   input logic [CNT_W-1:0]        count_o,
   input logic                    dir_o,
   input logic                    run_o,
   input logic                    ovf_evt_o,
   input logic                    trg_evt_o,
   input logic                    cnt_evt_o,
   input logic [NUM_CC-1:0]       mc_evt_o
);

   assert_retrig_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trg_evt_o |-> (run_o && count_o == ($past(dir_o) ? $past(top_i) : '0)));

   assert_step_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_o != $past(count_o) && $past(cnt_oe_i) && $past(trg_oe_i) && !trg_evt_o)
      |-> cnt_evt_o);

   assert_wrap_value_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_evt_o |-> (count_o == '0 || count_o == $past(top_i)));

   assert_ovf_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_evt_o |-> $past(ovf_oe_i));

   assert_trg_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trg_evt_o |-> $past(trg_oe_i));

   generate
      for (genvar n = 0; n < NUM_CC; n++) begin : g_mc
         assert_mc_value_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            mc_evt_o[n] |-> ($past(mc_oe_i[n]) &&
                             count_o == $past(cmp_i[n*CNT_W +: CNT_W])));
      end
   endgenerate

endmodule

bind evt_timer_ctrl evt_timer_ctrl_chk #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .top_i     (top_i),
   .cmp_i     (cmp_i),
   .ovf_oe_i  (ovf_oe_i),
   .trg_oe_i  (trg_oe_i),
   .cnt_oe_i  (cnt_oe_i),
   .mc_oe_i   (mc_oe_i),
   .count_o   (count_o),
   .dir_o     (dir_o),
   .run_o     (run_o),
   .ovf_evt_o (ovf_evt_o),
   .trg_evt_o (trg_evt_o),
   .cnt_evt_o (cnt_evt_o),
   .mc_evt_o  (mc_evt_o)
);

// File: tb/evt_timer_ctrl_tb_top.sv
module evt_timer_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          presc = 1'b0;
   logic [1:0]    evt = 2'b00, inv = 2'b00, en = 2'b00;
   logic [2:0]    ev0 = 3'd0, ev1 = 3'd0;
   logic [W-1:0]  top = 8'd10;
   logic [NC*W-1:0] cmp = {8'd10, 8'd3};
   logic          ovf_oe = 1'b1, trg_oe = 1'b1, cnt_oe = 1'b1;
   logic [NC-1:0] mc_oe = 2'b11;
   logic [W-1:0]  count;
   logic          dir, run, ovf_evt, trg_evt, cnt_evt;
   logic [NC-1:0] mc_evt;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_timer_ctrl #(.CNT_W(W), .NUM_CC(NC), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .presc_tick_i(presc), .evt_i(evt),
      .evt_inv_i(inv), .evt_en_i(en), .ev0_act_i(ev0), .ev1_act_i(ev1),
      .top_i(top), .cmp_i(cmp), .ovf_oe_i(ovf_oe), .trg_oe_i(trg_oe),
      .cnt_oe_i(cnt_oe), .mc_oe_i(mc_oe), .count_o(count), .dir_o(dir),
      .run_o(run), .ovf_evt_o(ovf_evt), .trg_evt_o(trg_evt),
      .cnt_evt_o(cnt_evt), .mc_evt_o(mc_evt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference step: returns {wrapped, new value}
   function automatic logic [W:0] ref_step(logic [W-1:0] c, logic [W-1:0] t, logic down);
      if (down) return (c == '0) ? {1'b1, t} : {1'b0, c - 1'b1};
      else      return (c >= t)  ? {1'b1, {W{1'b0}}} : {1'b0, c + 1'b1};
   endfunction

   // Cycle-level reference model of the requirements
   logic [1:0]   m_s0, m_s1, m_pv;
   logic [W-1:0] m_cnt;
   logic         m_dir, m_run, m_ovf, m_trg, m_cev;
   logic [NC-1:0] m_mc;

   always @(posedge clk) begin : ref_model
      logic [1:0] lv, rs;
      logic rt, st, sp, ce, ic, dc, gm, fm, sm, es, ts, dn, upd, nrun, ndir;
      logic [W:0] r;
      logic [W-1:0] nc;
      if (!rst_n) begin
         m_s0 = 0; m_s1 = 0; m_pv = 0; m_cnt = 0; m_dir = 0; m_run = 0;
         m_ovf = 0; m_trg = 0; m_cev = 0; m_mc = 0;
      end else begin
         lv = m_s1 ^ inv;
         rs = lv & ~m_pv;
         rt = (en[0] && ev0 == 3'd1 && rs[0]) || (en[1] && ev1 == 3'd1 && rs[1]);
         st = en[0] && ev0 == 3'd3 && rs[0];
         ce = en[0] && ev0 == 3'd2 && rs[0];
         ic = en[0] && ev0 == 3'd4 && rs[0];
         sp = en[1] && ev1 == 3'd3 && rs[1];
         dc = en[1] && ev1 == 3'd4 && rs[1];
         gm = en[0] && ev0 == 3'd5;
         fm = !(en[0] && (ev0 == 3'd2 || ev0 == 3'd5));
         sm = en[0] && ev0 == 3'd3;
         ndir = (en[1] && ev1 == 3'd2) ? lv[1] : m_dir;
         nrun = m_run; nc = m_cnt; upd = 0;
         m_ovf = 0; m_trg = 0; m_cev = 0;
         if (rt) begin
            nc = m_dir ? top : '0; nrun = 1; upd = 1; m_trg = trg_oe;
         end else begin
            if (st && !m_run) nrun = 1;
            if (sp) nrun = 0;
            ts = presc && ((gm && lv[0]) || (fm && m_run && !sp));
            es = ce || ic || dc;
            dn = ce ? m_dir : ic ? 1'b0 : dc ? 1'b1 : m_dir;
            if (es || ts) begin
               r = ref_step(m_cnt, top, dn);
               nc = r[W-1:0]; upd = 1; m_ovf = r[W] & ovf_oe; m_cev = cnt_oe;
               if (!es && sm && ((dn && nc == '0) || (!dn && nc == top))) nrun = 0;
            end
         end
         for (int n = 0; n < NC; n++)
            m_mc[n] = upd && nc == cmp[n*W +: W] && mc_oe[n];
         m_cnt = nc; m_run = nrun; m_dir = ndir;
         m_pv = lv; m_s1 = m_s0; m_s0 = evt;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R4 count",      count,   m_cnt);
         chk("R9 direction",  dir,     m_dir);
         chk("R6 running",    run,     m_run);
         chk("R10 overflow",  ovf_evt, m_ovf);
         chk("R3 retrigger",  trg_evt, m_trg);
         chk("R12 step",      cnt_evt, m_cev);
         chk("R11 compare",   mc_evt,  m_mc);
      end
   end

   task automatic pulse(input int idx);
      evt[idx] = 1'b1;
      @(negedge clk);
      evt[idx] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      presc = 1'b1;
      repeat (n) @(negedge clk);
      presc = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset count", count, 0);
      chk("R1 reset dir", dir, 0);
      chk("R1 reset run", run, 0);
      chk("R1 reset pulses", {ovf_evt, trg_evt, cnt_evt, mc_evt}, 0);
      cmp_en = 1'b1;
      en = 2'b11;

      ev0 = 3'd1; pulse(0);
      chk("R3 retrig up count", count, 0);
      chk("R3 retrig run", run, 1);
      ev0 = 3'd0; ticks(5);
      chk("R4 free run steps", count, 5);
      ev1 = 3'd3; pulse(1);
      ticks(6);
      chk("R9 stop freezes count", count, 5);
      chk("R9 stop clears run", run, 0);

      ev1 = 3'd0; ev0 = 3'd2; presc = 1'b1;
      pulse(0); pulse(0);
      presc = 1'b0;
      chk("R5 count on edges", count, 7);

      ev0 = 3'd4; ev1 = 3'd4; pulse(1);
      chk("R7 decrement", count, 6);
      ev1 = 3'd2; evt[1] = 1'b1; repeat (4) @(negedge clk);
      chk("R9 direction down", dir, 1);
      pulse(0);
      chk("R7 increment while down", count, 7);

      en[0] = 1'b0; pulse(0);
      chk("R2 disabled input", count, 7);
      en[0] = 1'b1; inv[0] = 1'b1; repeat (4) @(negedge clk);
      chk("R2 invert edge", count, 8);
      evt[0] = 1'b1; repeat (4) @(negedge clk);
      chk("R2 inverted fall ignored", count, 8);
      evt[0] = 1'b0; repeat (4) @(negedge clk);
      chk("R2 inverted rise", count, 9);
      inv[0] = 1'b0; repeat (4) @(negedge clk);

      ev0 = 3'd1; pulse(0);
      chk("R3 retrig down loads top", count, 10);
      ticks(11);
      chk("R10 underflow wrap", count, 10);

      ev1 = 3'd3; pulse(1);
      ev1 = 3'd2; evt[1] = 1'b0; repeat (4) @(negedge clk);
      ev1 = 3'd0; top = 8'd20;
      ev0 = 3'd3; pulse(0);
      chk("R6 start run", run, 1);
      ticks(3);
      chk("R6 start stepping", count, 13);
      pulse(0);
      chk("R6 repeat start ignored", count, 13);
      ticks(12);
      chk("R6 stop at top", count, 20);
      chk("R6 one-shot done", run, 0);

      ev0 = 3'd5; evt[0] = 1'b1; repeat (4) @(negedge clk);
      ticks(4);
      chk("R8 gated counting", count, 3);
      evt[0] = 1'b0; repeat (4) @(negedge clk);
      ticks(4);
      chk("R8 gate closed", count, 3);

      ev0 = 3'd4; ev1 = 3'd1;
      evt = 2'b11; @(negedge clk); evt = 2'b00; repeat (4) @(negedge clk);
      chk("R13 retrigger wins", count, 0);
      chk("R13 retrigger runs", run, 1);

      for (int ph = 0; ph < 30; ph++) begin
         ev0 = 3'(ph % 6);
         ev1 = 3'((ph / 6) % 5);
         inv = 2'($urandom % 4);
         en = {($urandom % 4) != 0, ($urandom % 4) != 0};
         top = 8'(3 + $urandom % 20);
         cmp = {8'($urandom % 24), 8'($urandom % 24)};
         {ovf_oe, trg_oe, cnt_oe} = 3'($urandom % 8);
         mc_oe = 2'($urandom % 4);
         repeat (200) begin
            @(negedge clk);
            presc = 1'($urandom % 2);
            for (int i = 0; i < 2; i++)
               if ($urandom % 5 == 0) evt[i] = ~evt[i];
         end
      end
      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule